// File: doc/BRIEF.md
# Packed-Operand Instruction Field Decoder

This block is a combinational front-end decoder for a compact instruction set whose register operands are split into two parts. The low two bits of each operand sit in fixed positions, but the high parts of all the operands in a halfword are folded together into one shared 5-bit field as a base-3 number. The decoder receives a fetch window of up to four bytes in little-endian order, together with a count of how many of those bytes are valid. It reports the instruction length, a valid flag, a format tag, up to six operand numbers and one decoded immediate.

The 16-bit short form is always tried first. The 32-bit long form is considered only when the short form cannot be decoded. Execution, register reads and mnemonic naming are the job of later stages. This block only splits fields and classifies the listed major opcodes. Any window that decodes in neither form, or that lacks the bytes its form needs, produces an all-zero result with valid low.

Top module: `pkd_decoder`

## Requirements
- R1: Byte k of the window occupies `fetch_bytes[8k+7:8k]`. The short halfword is byte 1 over byte 0. The long word is bytes 3..0, with byte 3 as its most significant byte.
- R2: Let C be halfword bits [10:6]. When C < 27 the halfword splits three ways. The operands are ((C mod 3)<<2)|b[5:4], (((C/3) mod 3)<<2)|b[3:2] and ((C/9)<<2)|b[1:0].
- R3: When C >= 27 the short halfword is a two-register form (format code 1) and occupies slots 0 and 1. The decoder adds 5 to C when bit 5 is set, then subtracts 27 to get x. The operands are ((x mod 3)<<2)|b[3:2] and ((x/3)<<2)|b[1:0]. The case C = 31 with bit 5 set is never a two-register form.
- R4: When the two-register form fails and C < 27, the opcode in bits [15:11] selects the format:
  - 0x02..0x09, 0x10, 0x11, 0x18 and 0x19 give three registers (code 2) in slots 0..2.
  - 0x00, 0x01, 0x12, 0x13 and 0x16 give register-register-immediate (code 3), with the third operand as the immediate.
  - 0x17 gives immediate-first (code 5): slots 0 and 1 hold the second and third operands, and the immediate holds the first.
  - Every other opcode makes the short form fail.
- R5: Opcodes 0x14 and 0x15 give format code 4. The third operand is a bit-position code that maps codes 0..11 to 32, 1, 2, 3, 4, 5, 6, 7, 8, 16, 24 and 32, and codes above 11 are invalid.
- R6: A decodable short halfword always yields length 2, whatever the upper bytes hold.
- R7: Long form, length 4. The long opcode is {bits[31:27], bits[19:16]}, and the operands come from the low halfword using the R2 packing, which must be valid. The opcode classes are:
  - 0x12C, 0x12D and 0x12E: code 8, with the bit-position immediate.
  - 0x13C and 0x14C: code 7, with a plain immediate.
  - 0x0C, 0x1C through 0x9C, 0x10C, 0x11C, 0x15C, 0x18C and 0x19C: code 6, three registers.
- R8: Six-register form (code 9). When the long opcode is none of those listed in R7 and bits[31:27] are 0, the form is valid when both halfwords split three ways. Slots 0..2 take the low halfword's operands and slots 3..5 take the upper halfword's.
- R9: A byte count below 2 is always invalid. A long form with a byte count below 4 is invalid.
- R10: When valid is low, the length, the format code, all operand slots and the immediate are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_bytes | input | 32 | Fetch window, byte k at bits [8k+7:8k] |
| byte_count | input | 3 | Number of valid bytes in the window (0..4) |
| insn_valid | output | 1 | A short or long form decoded |
| insn_len | output | 3 | Instruction length in bytes: 2, 4, or 0 when invalid |
| insn_fmt | output | 4 | Format code (0 none, 1..9 as in the requirements) |
| opnd_slots | output | 24 | Six 4-bit operand slots, slot k at bits [4k+3:4k] |
| imm_value | output | 6 | Decoded immediate, zero when the format has none |

## Verification
Immediate assertions inside the modules check every evaluation for the following:
- Every operand that a packed field yields stays at or below 11.
- Bit-position values are non-zero and no larger than 32.
- A 4-byte result never appears with fewer than four bytes present.
- An invalid result is all zero.
- A decodable short halfword never reports length 4.

Only the bench scenarios can show that each packed value maps to the right operands, that each opcode selects the right format, and that the C = 31 rejection occurs. The same applies to the long and six-register fallbacks behind a failing short form. The bench compares every window against a model written with integer division and remainder.

// File: rtl/pkd_pkg.sv
package pkd_pkg;

   typedef enum logic [3:0] {
      FMT_NONE      = 4'd0,
      FMT_TWO_REG   = 4'd1,
      FMT_THREE_REG = 4'd2,
      FMT_RR_IMM    = 4'd3,
      FMT_RR_BIT    = 4'd4,
      FMT_IMM_RR    = 4'd5,
      FMT_L_THREE   = 4'd6,
      FMT_L_RR_IMM  = 4'd7,
      FMT_L_RR_BIT  = 4'd8,
      FMT_L_SIX     = 4'd9
   } pkd_fmt_e;

   typedef enum logic [2:0] {
      SC_NONE, SC_RRR, SC_RRI, SC_RRB, SC_IRR
   } pkd_short_cls_e;

   typedef enum logic [1:0] {
      LC_NONE, LC_RRR, LC_RRI, LC_RRB
   } pkd_long_cls_e;

   // major opcode of a short halfword that failed the two-register split
   function automatic pkd_short_cls_e short_class(input logic [4:0] opc);
      case (opc)
         5'h00, 5'h01, 5'h12, 5'h13, 5'h16: short_class = SC_RRI;
         5'h14, 5'h15:                      short_class = SC_RRB;
         5'h17:                             short_class = SC_IRR;
         5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07, 5'h08, 5'h09,
         5'h10, 5'h11, 5'h18, 5'h19:        short_class = SC_RRR;
         default:                           short_class = SC_NONE;
      endcase
   endfunction

   // nine-bit long opcode {word[31:27], word[19:16]}
   function automatic pkd_long_cls_e long_class(input logic [8:0] opc);
      case (opc)
         9'h12C, 9'h12D, 9'h12E: long_class = LC_RRB;
         9'h13C, 9'h14C:         long_class = LC_RRI;
         9'h00C, 9'h01C, 9'h02C, 9'h03C, 9'h04C, 9'h05C, 9'h06C, 9'h07C,
         9'h08C, 9'h09C, 9'h10C, 9'h11C, 9'h15C, 9'h18C, 9'h19C:
                                 long_class = LC_RRR;
         default:                long_class = LC_NONE;
      endcase
   endfunction

endpackage

// File: rtl/pkd_tri_unpack.sv
module pkd_tri_unpack #(
   parameter int HALF_W = 16,
   parameter int REG_W  = 4
) (
   input  logic [HALF_W-1:0] half,
   output logic              ok,
   output logic [REG_W-1:0]  op_a,
   output logic [REG_W-1:0]  op_b,
   output logic [REG_W-1:0]  op_c
);
   localparam int LIMIT = 27;

   logic [4:0] packed_f;
   logic [4:0] third;
   logic [1:0] hi_a, hi_b, hi_c;

   generate
      if (HALF_W != 16) begin : g_bad_half
         $error("pkd_tri_unpack: HALF_W must be 16");
      end
      if (REG_W != 4) begin : g_bad_reg
         $error("pkd_tri_unpack: REG_W must be 4");
      end
   endgenerate

   assign packed_f = half[10:6];
   assign ok       = (packed_f < 5'(LIMIT));
   assign third    = packed_f / 5'd3;
   assign hi_a     = 2'(packed_f % 5'd3);
   assign hi_b     = 2'(third % 5'd3);
   assign hi_c     = 2'(packed_f / 5'd9);

   always_comb begin
      if (ok) begin
         op_a = {hi_a, half[5:4]};
         op_b = {hi_b, half[3:2]};
         op_c = {hi_c, half[1:0]};
      end else begin
         op_a = '0;
         op_b = '0;
         op_c = '0;
      end
   end

   always_comb begin
      if (!$isunknown(half) && ok) begin
         // R2
         tri_range_chk: assert (op_a <= 4'd11 && op_b <= 4'd11 && op_c <= 4'd11)
            else $error("three-way split produced an operand above 11");
      end
   end

endmodule

// File: rtl/pkd_duo_unpack.sv
module pkd_duo_unpack #(
   parameter int HALF_W = 16,
   parameter int REG_W  = 4
) (
   input  logic [HALF_W-1:0] half,
   output logic              ok,
   output logic [REG_W-1:0]  op_a,
   output logic [REG_W-1:0]  op_b
);
   localparam int BASE   = 27;
   localparam int BUMP   = 5;
   localparam int TOPVAL = 31;

   logic [4:0] packed_f;
   logic [5:0] bumped;
   logic [5:0] rel;

   assign packed_f = half[10:6];
   assign bumped   = {1'b0, packed_f} + (half[5] ? 6'(BUMP) : 6'd0);
   assign rel      = bumped - 6'(BASE);
   assign ok       = (packed_f >= 5'(BASE)) && !(half[5] && packed_f == 5'(TOPVAL));

   always_comb begin
      if (ok) begin
         op_a = {2'(rel % 6'd3), half[3:2]};
         op_b = {2'(rel / 6'd3), half[1:0]};
      end else begin
         op_a = '0;
         op_b = '0;
      end
   end

   always_comb begin
      if (!$isunknown(half) && ok) begin
         // R3
         duo_range_chk: assert (op_a <= 4'd11 && op_b <= 4'd11)
            else $error("two-way split produced an operand above 11");
      end
   end

endmodule

// File: rtl/pkd_bitpos_map.sv
module pkd_bitpos_map #(
   parameter int CODE_W = 4,
   parameter int IMM_W  = 6
) (
   input  logic [CODE_W-1:0] code,
   output logic              ok,
   output logic [IMM_W-1:0]  value
);
   generate
      if (IMM_W < 6) begin : g_bad_imm
         $error("pkd_bitpos_map: IMM_W must hold the value 32");
      end
   endgenerate

   always_comb begin
      ok    = 1'b1;
      value = '0;
      case (code)
         4'd0:  value = IMM_W'(32);
         4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8:
                value = IMM_W'(code);
         4'd9:  value = IMM_W'(16);
         4'd10: value = IMM_W'(24);
         4'd11: value = IMM_W'(32);
         default: ok = 1'b0;
      endcase
   end

   always_comb begin
      if (!$isunknown(code) && ok) begin
         // R5
         bitpos_value_chk: assert (value != '0 && value <= IMM_W'(32))
            else $error("bit-position value out of range");
      end
   end

endmodule

// File: rtl/pkd_decoder.sv
module pkd_decoder
   import pkd_pkg::*;
#(
   parameter int BYTES  = 4,
   parameter int REG_W  = 4,
   parameter int SLOTS  = 6,
   parameter int IMM_W  = 6
) (
   input  logic [BYTES*8-1:0]     fetch_bytes,
   input  logic [$clog2(BYTES+1)-1:0] byte_count,
   output logic                   insn_valid,
   output logic [2:0]             insn_len,
   output logic [3:0]             insn_fmt,
   output logic [SLOTS*REG_W-1:0] opnd_slots,
   output logic [IMM_W-1:0]       imm_value
);
   localparam int HALF_W  = 16;
   localparam int CNT_W   = $clog2(BYTES + 1);
   localparam int SHORT_N = HALF_W / 8;
   localparam int LONG_N  = 2 * SHORT_N;

   generate
      if (BYTES != LONG_N) begin : g_bad_bytes
         $error("pkd_decoder: window must be exactly four bytes");
      end
      if (SLOTS < 6) begin : g_bad_slots
         $error("pkd_decoder: six operand slots are needed");
      end
   endgenerate

   logic [7:0]        win_byte [BYTES];
   logic [HALF_W-1:0] lo_half, hi_half;

   genvar gi;
   generate
      for (gi = 0; gi < BYTES; gi++) begin : g_bytes
         assign win_byte[gi] = fetch_bytes[8*gi +: 8];
      end
   endgenerate

   assign lo_half = {win_byte[1], win_byte[0]};
   assign hi_half = {win_byte[3], win_byte[2]};

   logic             lo_tri_ok, hi_tri_ok, lo_duo_ok, bp_ok;
   logic [REG_W-1:0] lo_a, lo_b, lo_c, hi_a, hi_b, hi_c, duo_a, duo_b;
   logic [IMM_W-1:0] bp_val;

   pkd_tri_unpack #(.HALF_W(HALF_W), .REG_W(REG_W)) u_tri_lo (
      .half(lo_half), .ok(lo_tri_ok), .op_a(lo_a), .op_b(lo_b), .op_c(lo_c));
   pkd_tri_unpack #(.HALF_W(HALF_W), .REG_W(REG_W)) u_tri_hi (
      .half(hi_half), .ok(hi_tri_ok), .op_a(hi_a), .op_b(hi_b), .op_c(hi_c));
   pkd_duo_unpack #(.HALF_W(HALF_W), .REG_W(REG_W)) u_duo_lo (
      .half(lo_half), .ok(lo_duo_ok), .op_a(duo_a), .op_b(duo_b));
   pkd_bitpos_map #(.CODE_W(REG_W), .IMM_W(IMM_W)) u_bitpos (
      .code(lo_c), .ok(bp_ok), .value(bp_val));

   pkd_short_cls_e s_cls;
   pkd_long_cls_e  l_cls;
   logic           has_short, has_long, short_hit, long_hit, six_hit;
   logic [REG_W-1:0] slot_d [SLOTS];

   assign s_cls     = short_class(lo_half[15:11]);
   assign l_cls     = long_class({hi_half[15:11], hi_half[3:0]});
   assign has_short = (byte_count >= CNT_W'(SHORT_N));
   assign has_long  = (byte_count >= CNT_W'(LONG_N));

   assign short_hit = has_short &&
      (lo_duo_ok || (lo_tri_ok && s_cls != SC_NONE && (s_cls != SC_RRB || bp_ok)));
   assign six_hit   = (l_cls == LC_NONE) && (hi_half[15:11] == 5'd0) && hi_tri_ok;
   assign long_hit  = !short_hit && has_long && lo_tri_ok &&
      (six_hit || (l_cls != LC_NONE && (l_cls != LC_RRB || bp_ok)));

   always_comb begin
      insn_valid = short_hit || long_hit;
      insn_len   = short_hit ? 3'(SHORT_N) : (long_hit ? 3'(LONG_N) : 3'd0);
      insn_fmt   = FMT_NONE;
      imm_value  = '0;
      for (int k = 0; k < SLOTS; k++) slot_d[k] = '0;
      if (short_hit) begin
         if (lo_duo_ok) begin
            insn_fmt  = FMT_TWO_REG;
            slot_d[0] = duo_a;
            slot_d[1] = duo_b;
         end else begin
            case (s_cls)
               SC_RRR: begin
                  insn_fmt  = FMT_THREE_REG;
                  slot_d[0] = lo_a; slot_d[1] = lo_b; slot_d[2] = lo_c;
               end
               SC_RRI: begin
                  insn_fmt  = FMT_RR_IMM;
                  slot_d[0] = lo_a; slot_d[1] = lo_b;
                  imm_value = IMM_W'(lo_c);
               end
               SC_RRB: begin
                  insn_fmt  = FMT_RR_BIT;
                  slot_d[0] = lo_a; slot_d[1] = lo_b;
                  imm_value = bp_val;
               end
               SC_IRR: begin
                  insn_fmt  = FMT_IMM_RR;
                  slot_d[0] = lo_b; slot_d[1] = lo_c;
                  imm_value = IMM_W'(lo_a);
               end
               default: insn_fmt = FMT_NONE;
            endcase
         end
      end else if (long_hit) begin
         slot_d[0] = lo_a;
         slot_d[1] = lo_b;
         case (l_cls)
            LC_RRR: begin
               insn_fmt  = FMT_L_THREE;
               slot_d[2] = lo_c;
            end
            LC_RRI: begin
               insn_fmt  = FMT_L_RR_IMM;
               imm_value = IMM_W'(lo_c);
            end
            LC_RRB: begin
               insn_fmt  = FMT_L_RR_BIT;
               imm_value = bp_val;
            end
            default: begin
               insn_fmt  = FMT_L_SIX;
               slot_d[2] = lo_c;
               slot_d[3] = hi_a; slot_d[4] = hi_b; slot_d[5] = hi_c;
            end
         endcase
      end
   end

   generate
      for (gi = 0; gi < SLOTS; gi++) begin : g_slots
         assign opnd_slots[gi*REG_W +: REG_W] = slot_d[gi];
      end
   endgenerate

   always_comb begin
      if (!$isunknown({fetch_bytes, byte_count})) begin
         // R10
         idle_zero_chk: assert (insn_valid || (insn_len == 3'd0 && insn_fmt == 4'd0 &&
                                opnd_slots == '0 && imm_value == '0))
            else $error("invalid result carries non-zero fields");
         // R9
         long_bytes_chk: assert (insn_len != 3'(LONG_N) || has_long)
            else $error("long length reported with too few bytes");
         // R6
         short_first_chk: assert (!(has_short && lo_duo_ok) || insn_len == 3'(SHORT_N))
            else $error("decodable short halfword not reported as length 2");
      end
   end

endmodule

// File: tb/tb_pkd_decoder.sv
module tb_pkd_decoder;
   logic        clk = 1'b0;
   logic [31:0] fetch_bytes;
   logic [2:0]  byte_count;
   logic        insn_valid;
   logic [2:0]  insn_len;
   logic [3:0]  insn_fmt;
   logic [23:0] opnd_slots;
   logic [5:0]  imm_value;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   pkd_decoder dut (
      .fetch_bytes(fetch_bytes), .byte_count(byte_count),
      .insn_valid(insn_valid), .insn_len(insn_len), .insn_fmt(insn_fmt),
      .opnd_slots(opnd_slots), .imm_value(imm_value));

   function automatic int bitpos(input int code);
      case (code)
         0: return 32;
         9: return 16;
         10: return 24;
         11: return 32;
         default: return code;
      endcase
   endfunction

   function automatic bit in_list(input int v, input int lst[$]);
      foreach (lst[i]) if (lst[i] == v) return 1'b1;
      return 1'b0;
   endfunction

   // expected result from the requirement text, built with integer div and mod
   function automatic void model(input logic [31:0] w, input int n,
                                 output logic [37:0] exp_o);
      int c, x, a, b, cc, opc, lop, cu, ua, ub, uc;
      int fmt, len, imm;
      int s[6];
      logic [15:0] h, u;
      fmt = 0; len = 0; imm = 0;
      for (int k = 0; k < 6; k++) s[k] = 0;
      h = w[15:0];
      u = w[31:16];
      c = int'(h[10:6]);
      a = (c % 3) * 4 + int'(h[5:4]);
      b = ((c / 3) % 3) * 4 + int'(h[3:2]);
      cc = (c / 9) * 4 + int'(h[1:0]);
      opc = int'(h[15:11]);
      if (n >= 2) begin
         if (c >= 27 && !(c == 31 && h[5])) begin
            x = c + (h[5] ? 5 : 0) - 27;
            fmt = 1; s[0] = (x % 3) * 4 + int'(h[3:2]); s[1] = (x / 3) * 4 + int'(h[1:0]);
         end else if (c < 27) begin
            if (in_list(opc, '{0, 1, 18, 19, 22})) begin
               fmt = 3; s[0] = a; s[1] = b; imm = cc;
            end else if (in_list(opc, '{20, 21}) && cc <= 11) begin
               fmt = 4; s[0] = a; s[1] = b; imm = bitpos(cc);
            end else if (opc == 23) begin
               fmt = 5; s[0] = b; s[1] = cc; imm = a;
            end else if (in_list(opc, '{2, 3, 4, 5, 6, 7, 8, 9, 16, 17, 24, 25})) begin
               fmt = 2; s[0] = a; s[1] = b; s[2] = cc;
            end
         end
         if (fmt != 0) len = 2;
      end
      if (fmt == 0 && n >= 4 && c < 27) begin
         lop = int'(w[31:27]) * 16 + int'(w[19:16]);
         cu = int'(u[10:6]);
         if (in_list(lop, '{'h12C, 'h12D, 'h12E}) && cc <= 11) begin
            fmt = 8; s[0] = a; s[1] = b; imm = bitpos(cc);
         end else if (in_list(lop, '{'h13C, 'h14C})) begin
            fmt = 7; s[0] = a; s[1] = b; imm = cc;
         end else if (in_list(lop, '{'h0C, 'h1C, 'h2C, 'h3C, 'h4C, 'h5C, 'h6C, 'h7C,
                                     'h8C, 'h9C, 'h10C, 'h11C, 'h15C, 'h18C, 'h19C})) begin
            fmt = 6; s[0] = a; s[1] = b; s[2] = cc;
         end else if (w[31:27] == 5'd0 && cu < 27) begin
            ua = (cu % 3) * 4 + int'(u[5:4]);
            ub = ((cu / 3) % 3) * 4 + int'(u[3:2]);
            uc = (cu / 9) * 4 + int'(u[1:0]);
            fmt = 9; s[0] = a; s[1] = b; s[2] = cc; s[3] = ua; s[4] = ub; s[5] = uc;
         end
         if (fmt != 0) len = 4;
      end
      exp_o = {(fmt != 0), 3'(len), 4'(fmt),
               4'(s[5]), 4'(s[4]), 4'(s[3]), 4'(s[2]), 4'(s[1]), 4'(s[0]), 6'(imm)};
   endfunction

   function automatic string tag_of(input int fmt);
      case (fmt)
         1: return "R3";
         2: return "R2";
         3, 5: return "R4";
         4: return "R5";
         6, 7, 8: return "R7";
         9: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic run(input logic [31:0] w, input int n, input string tag);
      logic [37:0] exp_o, act_o;
      string t;
      @(negedge clk);
      fetch_bytes = w;
      byte_count  = 3'(n);
      @(posedge clk);
      #1;
      model(w, n, exp_o);
      act_o = {insn_valid, insn_len, insn_fmt, opnd_slots, imm_value};
      t = (tag == "") ? tag_of(int'(exp_o[33:30])) : tag;
      checks++;
      if (act_o !== exp_o) begin
         failures++;
         $display("FAIL %s window=%h n=%0d actual=%h expected=%h", t, w, n, act_o, exp_o);
      end
   endtask

   function automatic logic [15:0] mk(input int opc, input int c, input int low);
      return {5'(opc), 5'(c), 6'(low)};
   endfunction

   initial begin
      #(200000 * 10);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] w;
      void'($urandom(32'h5EED_0042));
      fetch_bytes = '0;
      byte_count  = '0;
      // R10: empty window at start-up gives all-zero outputs
      run(32'h0, 0, "R10");
      // R9: one byte cannot hold any form
      run({16'h0, mk(2, 3, 5)}, 1, "R9");
      // R2: highest three-way value, every operand 11
      run({16'h0, mk(2, 26, 63)}, 2, "R2");
      // R3: C=31 with bit 5 set is rejected by the two-register split, unlisted opcode
      run({16'h0, mk(31, 31, 6'b100101)}, 2, "R3");
      run({16'h0, mk(2, 31, 6'b100101)}, 4, "R3");
      // R3: C=31 with bit 5 clear is a two-register form
      run({16'h0, mk(31, 31, 6'b011011)}, 2, "R3");
      // R5: every bit-position code through the short form
      for (int k = 0; k < 12; k++)
         run({16'h0, mk(20 + (k % 2), 9 * (k / 4), k % 4)}, 2, "R5");
      // R4: immediate-first opcode
      run({16'h0, mk(23, 14, 6'b110110)}, 2, "R4");
      // R4: unlisted short opcode with only two bytes fails
      run({16'h0, mk(10, 4, 7)}, 2, "R4");
      // R7 and R1: long bit-position form assembled from the upper bytes
      w = {5'h12, 5'd7, 2'b01, 4'hC, mk(31, 13, 6'b011011)};
      run(w, 4, "R1");
      run(w, 3, "R9");
      // R7: long plain immediate and long three-register
      run({5'h14, 5'd2, 2'b11, 4'hC, mk(30, 20, 6'b101010)}, 4, "R7");
      run({5'h09, 5'd0, 2'b00, 4'hC, mk(15, 8, 6'b000111)}, 4, "R7");
      // R8: six-register form and a failing upper half
      run({5'd0, 5'd20, 6'b100111, mk(31, 5, 6'b110001)}, 4, "R8");
      run({5'd0, 5'd29, 6'b100111, mk(31, 5, 6'b110001)}, 4, "R8");
      // R6: short form wins over a listed long opcode
      run({5'h12, 5'd7, 2'b01, 4'hC, mk(2, 3, 6'b010101)}, 4, "R6");
      // R2 and R3: sweep every packed value with random low bits and opcodes
      for (int c = 0; c < 32; c++) begin
         for (int r = 0; r < 40; r++) begin
            w = $urandom;
            w[10:6] = 5'(c);
            run(w, 4, "");
         end
      end
      // R9: random windows with random byte counts
      for (int r = 0; r < 600; r++) begin
         w = $urandom;
         if (r % 3 == 0) w[15:11] = 5'h1F;
         if (r % 5 == 0) w[31:27] = 5'd0;
         run(w, int'($urandom_range(0, 4)), "");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule